// File: doc/BRIEF.md
# Sliced Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a small load/store processor datapath. It takes two operand words and a 4-bit operation code, and returns a result word, a carry flag and a signed-overflow flag in the same cycle. Immediates are expected to be sign- or zero-extended by the decoder before they reach the operands.

The datapath is a ripple of identical one-bit slices. Each slice holds an AND gate, an OR gate, a full adder and a result selector. A small decoder turns the operation code into slice controls: operand-B inversion, carry seed and result pick. Edge logic at the top slice derives overflow and the set-less-than outcome. That outcome is routed back into the lowest slice.

Top module: `alu_core`

## Requirements
- R1: Codes 0 (signed add) and 1 (unsigned add) give result = (A + B) mod 2^WIDTH, and carry_out equals the carry out of the top bit.
- R2: Codes 2 (signed subtract) and 3 (unsigned subtract) give result = (A + ~B + 1) mod 2^WIDTH. carry_out is the carry out of that sum, so 1 means no borrow. Subtracting equal operands yields 0 with carry_out = 1.
- R3: For codes 0 and 2, overflow is 1 exactly when the true signed result lies outside the two's-complement range of WIDTH bits.
- R4: Codes 1 and 3 never raise overflow.
- R5: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) give the bitwise function of A and B. Both carry_out and overflow are 0.
- R6: Code 8 (signed set-less-than) returns 1 in bit 0 when A < B as signed numbers, including cases where A − B overflows. All other result bits are 0, and both flags are 0.
- R7: Code 9 (unsigned set-less-than) returns 1 in bit 0 when A < B as unsigned numbers. All other result bits are 0, and both flags are 0.
- R8: Codes 10 to 15 return an all-zero result with carry_out = 0 and overflow = 0.
- R9: A signed add of operands whose top bits differ never raises overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand (subtrahend / compared value) |
| mode | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Adder carry out for codes 0 to 3, else 0 |
| overflow | output | 1 | Signed overflow for codes 0 and 2, else 0 |

## Verification
The bench builds the block with the default WIDTH of 32. At that width the sign boundaries 0x7FFFFFFF and 0x80000000 can be hit directly, so both overflow directions of add and subtract are exercised. So are the signed compares where A − B wraps, and the all-ones plus one carry case. Random operand pairs over all sixteen codes cover the decoder, including the six unused codes.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDU = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBU = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_NOR  = 4'd7;
  localparam logic [3:0] OP_SLT  = 4'd8;
  localparam logic [3:0] OP_SLTU = 4'd9;

  typedef enum logic [2:0] {
    PICK_ZERO = 3'd0,
    PICK_AND  = 3'd1,
    PICK_OR   = 3'd2,
    PICK_XOR  = 3'd3,
    PICK_NOR  = 3'd4,
    PICK_SUM  = 3'd5,
    PICK_LESS = 3'd6
  } pick_e;

  typedef struct packed {
    logic  invert_b;
    logic  carry_seed;
    pick_e pick;
    logic  arith;
    logic  signed_arith;
    logic  signed_cmp;
  } slice_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0]  mode,
  output slice_ctrl_t ctrl
);

  always_comb begin
    ctrl.invert_b     = 1'b0;
    ctrl.carry_seed   = 1'b0;
    ctrl.pick         = PICK_ZERO;
    ctrl.arith        = 1'b0;
    ctrl.signed_arith = 1'b0;
    ctrl.signed_cmp   = 1'b0;
    case (mode)
      OP_ADD: begin
        ctrl.pick         = PICK_SUM;
        ctrl.arith        = 1'b1;
        ctrl.signed_arith = 1'b1;
      end
      OP_ADDU: begin
        ctrl.pick  = PICK_SUM;
        ctrl.arith = 1'b1;
      end
      OP_SUB: begin
        ctrl.invert_b     = 1'b1;
        ctrl.carry_seed   = 1'b1;
        ctrl.pick         = PICK_SUM;
        ctrl.arith        = 1'b1;
        ctrl.signed_arith = 1'b1;
      end
      OP_SUBU: begin
        ctrl.invert_b   = 1'b1;
        ctrl.carry_seed = 1'b1;
        ctrl.pick       = PICK_SUM;
        ctrl.arith      = 1'b1;
      end
      OP_AND: ctrl.pick = PICK_AND;
      OP_OR:  ctrl.pick = PICK_OR;
      OP_XOR: ctrl.pick = PICK_XOR;
      OP_NOR: ctrl.pick = PICK_NOR;
      OP_SLT: begin
        ctrl.invert_b   = 1'b1;
        ctrl.carry_seed = 1'b1;
        ctrl.pick       = PICK_LESS;
        ctrl.signed_cmp = 1'b1;
      end
      OP_SLTU: begin
        ctrl.invert_b   = 1'b1;
        ctrl.carry_seed = 1'b1;
        ctrl.pick       = PICK_LESS;
      end
      default: ctrl.pick = PICK_ZERO;
    endcase
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic  a_bit,
  input  logic  b_bit,
  input  logic  carry_in,
  input  logic  invert_b,
  input  logic  less_in,
  input  pick_e pick,
  output logic  sum_bit,
  output logic  res_bit,
  output logic  carry_next
);

  logic b_eff;
  logic and_g;
  logic or_g;
  logic half;

  always_comb begin
    b_eff      = b_bit ^ invert_b;
    and_g      = a_bit & b_bit;
    or_g       = a_bit | b_bit;
    half       = a_bit ^ b_eff;
    sum_bit    = half ^ carry_in;
    carry_next = (a_bit & b_eff) | (carry_in & half);
  end

  always_comb begin
    case (pick)
      PICK_AND:  res_bit = and_g;
      PICK_OR:   res_bit = or_g;
      PICK_XOR:  res_bit = a_bit ^ b_bit;
      PICK_NOR:  res_bit = or_g ^ 1'b1;
      PICK_SUM:  res_bit = sum_bit;
      PICK_LESS: res_bit = less_in;
      default:   res_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_msb_edge.sv
module alu_msb_edge
  import alu_pkg::*;
(
  input  slice_ctrl_t ctrl,
  input  logic        carry_into_top,
  input  logic        carry_from_top,
  input  logic        sum_top,
  output logic        less_flag,
  output logic        ovf_flag,
  output logic        carry_flag
);

  logic wrap;

  always_comb begin
    wrap       = carry_into_top ^ carry_from_top;
    less_flag  = ctrl.signed_cmp ? (sum_top ^ wrap) : ~carry_from_top;
    ovf_flag   = ctrl.signed_arith & wrap;
    carry_flag = ctrl.arith & carry_from_top;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);

  localparam int TOP = WIDTH - 1;

  slice_ctrl_t      ctrl;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] sums;
  logic             less_flag;

  alu_decode u_decode (
    .mode (mode),
    .ctrl (ctrl)
  );

  assign chain[0] = ctrl.carry_seed;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = less_flag;
    end else begin : g_rest
      assign less_in = 1'b0;
    end
    alu_bit_slice u_slice (
      .a_bit      (opnd_a[i]),
      .b_bit      (opnd_b[i]),
      .carry_in   (chain[i]),
      .invert_b   (ctrl.invert_b),
      .less_in    (less_in),
      .pick       (ctrl.pick),
      .sum_bit    (sums[i]),
      .res_bit    (result[i]),
      .carry_next (chain[i+1])
    );
  end

  alu_msb_edge u_edge (
    .ctrl           (ctrl),
    .carry_into_top (chain[TOP]),
    .carry_from_top (chain[WIDTH]),
    .sum_top        (sums[TOP]),
    .less_flag      (less_flag),
    .ovf_flag       (overflow),
    .carry_flag     (carry_out)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       mode,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             overflow
);

  always_comb begin
    if (mode == 4'd1 || mode == 4'd3) begin
      // R4
      unsigned_no_ovf_chk: assert (!overflow);
    end
    if (mode >= 4'd4 && mode <= 4'd7) begin
      // R5
      logic_flags_chk: assert (!overflow && !carry_out);
    end
    if (mode == 4'd4) begin
      // R5
      and_within_or_chk: assert ((result & ~(opnd_a | opnd_b)) == '0);
    end
    if (mode == 4'd8 || mode == 4'd9) begin
      // R6
      slt_zero_ext_chk: assert (result[WIDTH-1:1] == '0 && !overflow && !carry_out);
    end
    if (mode >= 4'd10) begin
      // R8
      unused_quiet_chk: assert (result == '0 && !overflow && !carry_out);
    end
    if (mode == 4'd0 && (opnd_a[WIDTH-1] != opnd_b[WIDTH-1])) begin
      // R9
      mixed_sign_no_ovf_chk: assert (!overflow);
    end
    if (mode == 4'd3 && opnd_a == opnd_b) begin
      // R2
      equal_sub_chk: assert (result == '0 && carry_out);
    end
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .mode      (mode),
  .result    (result),
  .carry_out (carry_out),
  .overflow  (overflow)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [3:0]   mode;
  logic [W-1:0] result;
  logic         carry_out;
  logic         overflow;

  int checks = 0;
  int errors = 0;

  alu_core #(.WIDTH(W)) u_dut (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .mode      (mode),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [3:0] m);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         c;
    logic         v;
    r = '0; c = 1'b0; v = 1'b0;
    case (m)
      4'd0, 4'd1: begin
        s = {1'b0, a} + {1'b0, b};
        r = s[W-1:0]; c = s[W];
        if (m == 4'd0) v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'd2, 4'd3: begin
        s = {1'b0, a} + {1'b0, ~b} + 1;
        r = s[W-1:0]; c = s[W];
        if (m == 4'd2) v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~(a | b);
      4'd8: r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      4'd9: r = {{(W-1){1'b0}}, (a < b)};
      default: r = '0;
    endcase
    return {r, c, v};
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0: return "R1 R3";
      4'd1: return "R1 R4";
      4'd2: return "R2 R3";
      4'd3: return "R2 R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] m,
                       input string tag);
    logic [W+1:0] exp;
    @(negedge clk);
    opnd_a = a; opnd_b = b; mode = m;
    #2;
    exp = model(a, b, m);
    checks++;
    if ({result, carry_out, overflow} !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d a=%h b=%h: got res=%h c=%b v=%b, exp res=%h c=%b v=%b",
               tag, m, a, b, result, carry_out, overflow, exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    opnd_a = '0; opnd_b = '0; mode = 4'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero operands, add code
    apply(32'h0, 32'h0, 4'd0, "R1");
    // R1 carry from all-ones plus one
    apply(32'hFFFF_FFFF, 32'h1, 4'd1, "R1");
    // R3 positive overflow and negative overflow
    apply(32'h7FFF_FFFF, 32'h1, 4'd0, "R3");
    apply(32'h8000_0000, 32'h8000_0000, 4'd0, "R3");
    apply(32'h8000_0000, 32'h1, 4'd2, "R3");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd2, "R3");
    // R4 same operands unsigned never flag
    apply(32'h7FFF_FFFF, 32'h1, 4'd1, "R4");
    apply(32'h8000_0000, 32'h1, 4'd3, "R4");
    // R2 equal subtract and borrow
    apply(32'h1234_5678, 32'h1234_5678, 4'd3, "R2");
    apply(32'h0, 32'h1, 4'd3, "R2");
    // R9 mixed-sign adds
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'd0, "R9");
    apply(32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'd0, "R9");
    // R5 logic patterns
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd4, "R5");
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd5, "R5");
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 4'd6, "R5");
    apply(32'h0, 32'h0, 4'd7, "R5");
    // R6 signed compare including overflowing difference
    apply(32'h8000_0000, 32'h1, 4'd8, "R6");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'd8, "R6");
    apply(32'h5, 32'h5, 4'd8, "R6");
    // R7 unsigned compare
    apply(32'h1, 32'h8000_0000, 4'd9, "R7");
    apply(32'hFFFF_FFFF, 32'h0, 4'd9, "R7");
    // R8 every unused code
    for (int k = 10; k < 16; k++) apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(k), "R8");
    // random mix over all codes
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]   m;
      logic [W-1:0] a;
      logic [W-1:0] b;
      m = 4'($urandom_range(0, 15));
      a = $urandom();
      b = (n % 7 == 0) ? a : $urandom();
      if (n % 11 == 0) a[W-1] = ~b[W-1];
      apply(a, b, m, req_of(m));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule